// File: doc/BRIEF.md
# Multi-Cycle 16-bit Processor Core

This block is a compact processor core that runs a 16-bit instruction set over several clock cycles per instruction. Instructions and data live in one shared memory of 16-bit words. A Moore-style control machine steps every instruction through a fetch cycle, a decode cycle and a short sequence of execute cycles that depends on the instruction class. The core then returns to fetch.

A single ALU does all arithmetic. This includes advancing the program counter during fetch and forming load, store and branch addresses. The memory port is purely combinational on the read side. The word selected by `mem_addr` is expected on `mem_rdata` in the same cycle. A write takes effect at the clock edge that ends a cycle with `mem_wr` high.

The core holds eight general registers, a program counter, an instruction register and operand holding registers. A halt instruction parks the core until the next reset.

Top module: `cpu16_core`

## Requirements
- R1: While `rst_n` is low, and for two more rising edges after it is released, the core shows a fetch of address 0 (`mem_rd`=1, `mem_wr`=0). All eight registers read as zero. The first instruction word is latched on the third rising edge after release.
- R2: A fetch cycle drives `mem_addr` with the program counter and asserts `mem_rd`. The returned word is latched as the current instruction, and the program counter advances by one.
- R3: Opcode 0 in bits [15:13] is a register operation. Its source fields are bits [12:10] and [9:7], its destination is bits [6:4], and its function is bits [3:0]. Function 0 adds, 1 subtracts (first minus second), 2 is AND, 3 is OR, and 4 writes 1 if the first source is less than the second as a signed value (else 0). Each takes three cycles.
- R4: Immediate-format instructions carry a base register in bits [12:10], a data register in bits [9:7], and a 7-bit two's-complement offset in bits [6:0]. Opcode 1 (load) takes four cycles. Its third cycle reads the address base+offset, and its fourth cycle writes the returned word into the data register.
- R5: Opcode 2 (store) takes three cycles. Its third cycle asserts `mem_wr` with address base+offset and `mem_wdata` equal to the data register.
- R6: Opcode 3 (branch if equal) takes three cycles. When both registers are equal, the program counter becomes the already-advanced counter plus the sign-extended offset. Otherwise execution continues in sequence.
- R7: Opcode 4 writes base+sign-extended offset into the data register in three cycles.
- R8: Opcode 5 loads the program counter with the zero-extended 13-bit field in bits [12:0], in three cycles.
- R9: Opcode 7 halts the core. It then makes no memory access until reset, and a reset restarts execution from address 0.
- R10: Opcode 6, and opcode 0 with a function code above 4, complete in two cycles and change no register.
- R11: `mem_rd` and `mem_wr` are never high together, and the decode cycle makes no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 16 | Word address for the shared memory |
| mem_rd | output | 1 | Read strobe; data expected on `mem_rdata` in the same cycle |
| mem_wr | output | 1 | Write strobe; memory updates at the closing clock edge |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data from memory |

## Verification
The risky overlap is a store that rewrites the instruction word the very next fetch reads. The store's write lands at the same edge that closes its execute cycle, and the following fetch reads memory in the next cycle. The test program first loads an encoded instruction from a data word. It then stores that word over the halt placed at the following address. A correct core executes the new instruction instead of halting. The cycle-accurate model in the bench flags any stale fetch, either as a wrong bus sequence or as wrong register contents in the final dump. Branch and fetch also share the program counter and the ALU. A taken branch just after an increment must land on the target computed from the advanced counter, and this is judged by the address of the next fetch.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC_R,
    ST_LD_MEM,
    ST_LD_WB,
    ST_ST_MEM,
    ST_BEQ,
    ST_ADDI,
    ST_JUMP,
    ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic {
    SA_PC  = 1'b0,
    SA_REG = 1'b1
  } srca_e;

  typedef enum logic [1:0] {
    SB_REG = 2'd0,
    SB_ONE = 2'd1,
    SB_IMM = 2'd2
  } srcb_e;

  localparam logic [2:0] OPC_REG  = 3'd0;
  localparam logic [2:0] OPC_LOAD = 3'd1;
  localparam logic [2:0] OPC_STOR = 3'd2;
  localparam logic [2:0] OPC_BEQ  = 3'd3;
  localparam logic [2:0] OPC_ADDI = 3'd4;
  localparam logic [2:0] OPC_JUMP = 3'd5;
  localparam logic [2:0] OPC_HALT = 3'd7;
  localparam logic [3:0] FN_LAST  = 4'd4;

  typedef struct packed {
    logic    mem_rd;
    logic    mem_wr;
    logic    addr_alu;
    logic    ir_ld;
    logic    pc_ld;
    logic    pc_jump;
    logic    ab_ld;
    logic    mdr_ld;
    logic    rf_we;
    logic    rf_to_rd;
    logic    rf_from_mem;
    srca_e   src_a;
    srcb_e   src_b;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);

  logic [WIDTH-1:0] regs [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (hit) begin
        regs[i] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? WIDTH'(1) : '0;
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] opcode,
  input  logic [3:0] funct,
  input  logic       ab_equal,
  output state_e     state_o,
  output ctrl_t      ctl
);

  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (opcode)
          OPC_REG:  state_d = (funct <= FN_LAST) ? ST_EXEC_R : ST_FETCH;
          OPC_LOAD: state_d = ST_LD_MEM;
          OPC_STOR: state_d = ST_ST_MEM;
          OPC_BEQ:  state_d = ST_BEQ;
          OPC_ADDI: state_d = ST_ADDI;
          OPC_JUMP: state_d = ST_JUMP;
          OPC_HALT: state_d = ST_HALT;
          default:  state_d = ST_FETCH;
        endcase
      end
      ST_LD_MEM: state_d = ST_LD_WB;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.src_a  = SA_REG;
    ctl.src_b  = SB_REG;
    ctl.alu_op = ALU_ADD;
    unique case (state_q)
      ST_FETCH: begin
        ctl.mem_rd = 1'b1;
        ctl.ir_ld  = 1'b1;
        ctl.pc_ld  = 1'b1;
        ctl.src_a  = SA_PC;
        ctl.src_b  = SB_ONE;
      end
      ST_DECODE: ctl.ab_ld = 1'b1;
      ST_EXEC_R: begin
        ctl.rf_we    = 1'b1;
        ctl.rf_to_rd = 1'b1;
        ctl.alu_op   = alu_op_e'(funct[2:0]);
      end
      ST_LD_MEM: begin
        ctl.addr_alu = 1'b1;
        ctl.mem_rd   = 1'b1;
        ctl.mdr_ld   = 1'b1;
        ctl.src_b    = SB_IMM;
      end
      ST_LD_WB: begin
        ctl.rf_we       = 1'b1;
        ctl.rf_from_mem = 1'b1;
      end
      ST_ST_MEM: begin
        ctl.addr_alu = 1'b1;
        ctl.mem_wr   = 1'b1;
        ctl.src_b    = SB_IMM;
      end
      ST_BEQ: begin
        ctl.pc_ld = ab_equal;
        ctl.src_a = SA_PC;
        ctl.src_b = SB_IMM;
      end
      ST_ADDI: begin
        ctl.rf_we = 1'b1;
        ctl.src_b = SB_IMM;
      end
      ST_JUMP: begin
        ctl.pc_ld   = 1'b1;
        ctl.pc_jump = 1'b1;
      end
      default: ;
    endcase
  end

  assign state_o = state_q;

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int unsigned XLEN  = 16,
  parameter int unsigned NREGS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata
);

  localparam int unsigned RIDX_W = $clog2(NREGS);
  localparam int unsigned IMM_W  = 7;
  localparam int unsigned TGT_W  = 13;

  logic   rst_meta_q, rst_sync_q, rst_int_n;
  state_e state_q;
  ctrl_t  ctl;

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, mdr_q;
  logic [XLEN-1:0] alu_a, alu_b, alu_y, imm_sx, tgt_zx, pc_d, rf_wdata;
  logic [XLEN-1:0] rf_rdata_a, rf_rdata_b;
  logic [RIDX_W-1:0] rf_waddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign tgt_zx = {{(XLEN-TGT_W){1'b0}}, ir_q[TGT_W-1:0]};

  cpu16_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .opcode   (ir_q[15:13]),
    .funct    (ir_q[3:0]),
    .ab_equal (a_q == b_q),
    .state_o  (state_q),
    .ctl      (ctl)
  );

  cpu16_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we      (ctl.rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (ir_q[10 +: RIDX_W]),
    .raddr_b (ir_q[7 +: RIDX_W]),
    .rdata_a (rf_rdata_a),
    .rdata_b (rf_rdata_b)
  );

  always_comb begin
    alu_a = (ctl.src_a == SA_PC) ? pc_q : a_q;
    unique case (ctl.src_b)
      SB_ONE:  alu_b = XLEN'(1);
      SB_IMM:  alu_b = imm_sx;
      default: alu_b = b_q;
    endcase
  end

  cpu16_alu #(.WIDTH(XLEN)) u_alu (
    .op (ctl.alu_op),
    .a  (alu_a),
    .b  (alu_b),
    .y  (alu_y)
  );

  assign pc_d     = ctl.pc_jump ? tgt_zx : alu_y;
  assign rf_waddr = ctl.rf_to_rd ? ir_q[4 +: RIDX_W] : ir_q[7 +: RIDX_W];
  assign rf_wdata = ctl.rf_from_mem ? mdr_q : alu_y;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      mdr_q <= '0;
    end else begin
      if (ctl.pc_ld)  pc_q  <= pc_d;
      if (ctl.ir_ld)  ir_q  <= mem_rdata;
      if (ctl.ab_ld)  a_q   <= rf_rdata_a;
      if (ctl.ab_ld)  b_q   <= rf_rdata_b;
      if (ctl.mdr_ld) mdr_q <= mem_rdata;
    end
  end

  assign mem_addr  = ctl.addr_alu ? alu_y : pc_q;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign mem_wdata = b_q;

endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
  import cpu16_pkg::*;
#(
  parameter int unsigned XLEN = 16
) (
  input logic            clk,
  input logic            rst_n,
  input state_e          state,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] ir_q,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_rd,
  input logic            mem_wr
);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_decode_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE) |-> (!mem_rd && !mem_wr));

  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |-> (mem_rd && mem_addr == pc_q));

  p_fetch_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && state == ST_FETCH) |=> (pc_q == $past(pc_q) + XLEN'(1)));

  p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && state != ST_FETCH) |=> $stable(ir_q));

  p_jump_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && state == ST_JUMP) |=> (pc_q == {{(XLEN-13){1'b0}}, $past(ir_q[12:0])}));

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> (!mem_rd && !mem_wr));

  p_halt_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && state == ST_HALT) |=> (state == ST_HALT));

endmodule

bind cpu16_core cpu16_core_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .state    (state_q),
  .pc_q     (pc_q),
  .ir_q     (ir_q),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr)
);

// File: tb/cpu16_core_tb.sv
module cpu16_core_tb;

  localparam int M_FETCH = 0, M_DECODE = 1, M_EXR = 2, M_LDM = 3, M_LDW = 4,
                 M_STM = 5, M_BEQ = 6, M_ADDI = 7, M_JMP = 8, M_HALT = 9;

  logic        clk, rst_n;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;

  logic [15:0] mem     [256];
  logic [15:0] ref_mem [256];

  int          checks, fails, cyc, hold, m_st;
  logic [15:0] m_pc, m_ir, m_a, m_b, m_mdr;
  logic [15:0] m_r [8];

  cpu16_core u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  function automatic logic [15:0] enc_r(int rs, int rt, int rd, int fn);
    return {3'd0, 3'(rs), 3'(rt), 3'(rd), 4'(fn)};
  endfunction
  function automatic logic [15:0] enc_i(int op, int rs, int rt, int off);
    return {3'(op), 3'(rs), 3'(rt), 7'(off)};
  endfunction
  function automatic logic [15:0] sx(logic [15:0] w);
    return {{9{w[6]}}, w[6:0]};
  endfunction

  function automatic string tag_of(int st, logic [15:0] ir);
    if (!rst_n || hold > 0) return "R1";
    case (st)
      M_FETCH:  return "R2";
      M_DECODE: return (ir[15:13] == 3'd6 || (ir[15:13] == 3'd0 && ir[3:0] > 4)) ? "R10" : "R11";
      M_EXR:    return "R3";
      M_LDM, M_LDW: return "R4";
      M_STM:    return "R5";
      M_BEQ:    return "R6";
      M_ADDI:   return "R7";
      M_JMP:    return "R8";
      default:  return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic ok, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: %s", tag, cyc, msg);
    end
  endtask

  task automatic model_reset();
    m_st = M_FETCH; m_pc = '0; m_ir = '0; m_a = '0; m_b = '0; m_mdr = '0;
    for (int i = 0; i < 8; i++) m_r[i] = '0;
  endtask

  task automatic model_advance();
    logic [15:0] ea;
    ea = m_a + sx(m_ir);
    case (m_st)
      M_FETCH: begin m_ir = ref_mem[m_pc[7:0]]; m_pc = m_pc + 16'd1; m_st = M_DECODE; end
      M_DECODE: begin
        m_a = m_r[m_ir[12:10]]; m_b = m_r[m_ir[9:7]];
        case (m_ir[15:13])
          3'd0: m_st = (m_ir[3:0] <= 4) ? M_EXR : M_FETCH;
          3'd1: m_st = M_LDM;
          3'd2: m_st = M_STM;
          3'd3: m_st = M_BEQ;
          3'd4: m_st = M_ADDI;
          3'd5: m_st = M_JMP;
          3'd7: m_st = M_HALT;
          default: m_st = M_FETCH;
        endcase
      end
      M_EXR: begin
        case (m_ir[3:0])
          4'd0: m_r[m_ir[6:4]] = m_a + m_b;
          4'd1: m_r[m_ir[6:4]] = m_a - m_b;
          4'd2: m_r[m_ir[6:4]] = m_a & m_b;
          4'd3: m_r[m_ir[6:4]] = m_a | m_b;
          default: m_r[m_ir[6:4]] = ($signed(m_a) < $signed(m_b)) ? 16'd1 : 16'd0;
        endcase
        m_st = M_FETCH;
      end
      M_LDM:  begin m_mdr = ref_mem[ea[7:0]]; m_st = M_LDW; end
      M_LDW:  begin m_r[m_ir[9:7]] = m_mdr; m_st = M_FETCH; end
      M_STM:  begin ref_mem[ea[7:0]] = m_b; m_st = M_FETCH; end
      M_BEQ:  begin if (m_a == m_b) m_pc = m_pc + sx(m_ir); m_st = M_FETCH; end
      M_ADDI: begin m_r[m_ir[9:7]] = ea; m_st = M_FETCH; end
      M_JMP:  begin m_pc = {3'd0, m_ir[12:0]}; m_st = M_FETCH; end
      default: m_st = M_HALT;
    endcase
  endtask

  task automatic step();
    logic e_rd, e_wr, ok;
    logic [15:0] e_addr, e_wd;
    @(negedge clk);
    cyc++;
    if (!rst_n) begin model_reset(); hold = 1; end
    e_rd = (m_st == M_FETCH) || (m_st == M_LDM);
    e_wr = (m_st == M_STM);
    e_addr = (m_st == M_FETCH) ? m_pc : m_a + sx(m_ir);
    e_wd = m_b;
    ok = (mem_rd === e_rd) && (mem_wr === e_wr)
      && (!(e_rd || e_wr) || mem_addr === e_addr)
      && (!e_wr || mem_wdata === e_wd);
    check(tag_of(m_st, m_ir), ok,
      $sformatf("rd=%b wr=%b addr=%h wd=%h expected rd=%b wr=%b addr=%h wd=%h",
                mem_rd, mem_wr, mem_addr, mem_wdata, e_rd, e_wr, e_addr, e_wd));
    if (rst_n) begin
      if (hold > 0) hold--;
      else model_advance();
    end
  endtask

  task automatic run_to_halt();
    int n;
    n = 0;
    while (m_st != M_HALT && n < 2000) begin step(); n++; end
    if (n >= 2000) check("R9", 1'b0, "watchdog expired before halt");
    for (int i = 0; i < 12; i++) step();
  endtask

  task automatic check_dump();
    logic [15:0] exp_v [7];
    exp_v = '{16'h0006, 16'hFFFD, 16'h0002, 16'hFFF8, 16'h0002, 16'h8481, 16'h0001};
    for (int i = 0; i < 7; i++)
      check(i == 4 || i == 5 ? "R4" : (i < 2 ? "R7" : "R3"), mem[30 + i] === exp_v[i],
            $sformatf("reg r%0d dump=%h expected %h", i + 1, mem[30 + i], exp_v[i]));
    check("R5", mem[40] === 16'h0002, $sformatf("mem[40]=%h expected 0002", mem[40]));
    check("R5", mem[46] === 16'h0002, $sformatf("mem[46]=%h expected 0002", mem[46]));
    check("R5", mem[18] === 16'h8481, $sformatf("mem[18]=%h expected 8481", mem[18]));
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 0; hold = 1;
    rst_n = 1'b0;
    model_reset();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0]  = enc_i(4, 0, 1, 5);
    mem[1]  = enc_i(4, 0, 2, -3);
    mem[2]  = enc_r(1, 2, 3, 0);
    mem[3]  = enc_r(2, 1, 4, 1);
    mem[4]  = enc_r(1, 2, 5, 2);
    mem[5]  = enc_r(1, 2, 6, 3);
    mem[6]  = enc_r(2, 1, 7, 4);
    mem[7]  = enc_i(2, 0, 3, 40);
    mem[8]  = enc_i(1, 0, 5, 40);
    mem[9]  = enc_i(2, 4, 5, 54);
    mem[10] = enc_i(3, 3, 5, 2);
    mem[11] = 16'hE000;
    mem[12] = 16'hE000;
    mem[13] = enc_i(3, 1, 2, 5);
    mem[14] = 16'hC123;
    mem[15] = enc_r(1, 2, 1, 9);
    mem[16] = enc_i(1, 0, 6, 50);
    mem[17] = enc_i(2, 0, 6, 18);
    mem[18] = 16'hE000;
    mem[19] = {3'd5, 13'd22};
    mem[20] = 16'hE000;
    mem[21] = 16'hE000;
    for (int i = 0; i < 7; i++) mem[22 + i] = enc_i(2, 0, i + 1, 30 + i);
    mem[29] = 16'hE000;
    mem[50] = enc_i(4, 1, 1, 1);
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];

    for (int i = 0; i < 4; i++) step();
    rst_n = 1'b1;
    run_to_halt();
    check_dump();

    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    run_to_halt();
    check_dump();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule